// File: doc/BRIEF.md
# Transaction Rename-Map Checkpoint

This block holds the register-renaming state that a hardware transaction must be able to roll back to. It keeps the live architectural-to-physical map, which the rename stage writes as instructions are renamed. When the outermost transaction-begin instruction executes, the block copies that map into a snapshot and stores the abort handler address. It also sets a protect bit for every physical register named in the map at that moment. The free-list logic reads these protect bits and keeps those registers out of reuse, even after a later rename has overwritten them.

Begins inside a transaction that is already open take no new snapshot. They only raise the nesting depth. Each end lowers the depth by one, and only the end that brings the depth back to zero commits the transaction and drops the protect bits. An abort at any depth puts back the outermost snapshot, clears the protect bits and resets the depth. One cycle later it raises a redirect pulse carrying the outermost handler address, which the fetch unit follows.

Top module: `rename_ckpt`

## Requirements
- R1: After a synchronous active-low reset, map entry i holds physical register i, all protect bits are 0, the depth is 0 and the redirect pulse is low.
- R2: A rename write (write enable high, architectural index, physical index) changes that map entry on the next cycle. Map entry i is output on bits [i*PHYS_W +: PHYS_W].
- R3: A begin at depth 0 saves the map as it stood before that clock edge, records the handler PC and sets the depth to 1.
- R4: A begin at depth 0 sets the protect bit of every physical register held in the map at that moment. Protect bits are never cleared by later renames; only a commit or an abort clears them.
- R5: A begin at depth greater than 0 raises the depth by one and changes neither the snapshot nor the handler PC. At the maximum depth 2**DEPTH_W-1 the begin is ignored.
- R6: An end at depth greater than 0 lowers the depth by one. The end that reaches depth 0 clears every protect bit. An end at depth 0 is ignored.
- R7: An abort at depth greater than 0 does four things on the next cycle: the map equals the outermost snapshot, the protect bits are clear and the depth is 0. For that one cycle the redirect pulse is high, with the outermost handler PC on the redirect PC output.
- R8: An abort at depth 0 has no effect and gives no redirect pulse.
- R9: An abort in the same cycle as a begin, an end or a rename write takes priority, and the other inputs are dropped.
- R10: A begin and an end in the same cycle without an abort: the end acts and the begin is dropped.
- R11: A begin and a rename write in the same cycle: the snapshot holds the map before the write, and the write still updates the live map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_begin_i | input | 1 | Transaction-begin pulse |
| tx_begin_pc_i | input | PC_W | Abort handler address given with the begin |
| tx_end_i | input | 1 | Transaction-end pulse |
| tx_abort_i | input | 1 | Abort pulse |
| ren_we_i | input | 1 | Rename write enable |
| ren_arch_i | input | ARCH_W | Architectural register being renamed |
| ren_phys_i | input | PHYS_W | New physical register |
| map_o | output | NUM_ARCH*PHYS_W | Live rename map, entry i at bits [i*PHYS_W +: PHYS_W] |
| saved_o | output | NUM_PHYS | Protect bits, one per physical register |
| redirect_o | output | 1 | One-cycle fetch redirect after an abort |
| redirect_pc_o | output | PC_W | Handler address for the redirect |
| depth_o | output | DEPTH_W | Current nesting depth |

## Verification
The bench first sends plain renames with no transaction open, which shows whether the map update works on its own, apart from the checkpoint. It then runs directed sequences with one purpose each:
- a begin in the same cycle as a rename, to show whether the snapshot is taken before or after the write;
- a climb of nested begins past the depth limit, then ends back to zero and one more, to test saturation, commit and the ignored end;
- aborts at depth 0 and at depth 3, to separate an abort that is ignored from a real rollback and to show which handler is used;
- aborts together with a begin, an end and a rename, and a begin together with an end, to check each priority rule.

A long run of random inputs, compared every cycle with a behavioural model, then mixes all of these cases.

// File: rtl/rckpt_pkg.sv
// Package: shared control type for the rename-map checkpoint.
// Assumes nothing beyond the strobes being mutually consistent.
package rckpt_pkg;
    // Control strobes produced by the nesting controller, one cycle each.
    typedef struct packed {
        logic take_snap;   // outermost begin: copy map, arm protect bits
        logic restore;     // abort of an open transaction: roll back
        logic release_ck;  // final end: drop checkpoint
    } ckpt_ctl_t;
endpackage

// File: rtl/ckpt_nest_ctrl.sv
// Module: nesting controller. Tracks transaction depth, keeps the outermost
// handler PC, resolves input priority (abort > end > begin) and issues the
// checkpoint strobes and the one-cycle redirect.
// Assumes: begin/end/abort are single-cycle pulses from retirement.
module ckpt_nest_ctrl
    import rckpt_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int DEPTH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               begin_i,
    input  logic [PC_W-1:0]    begin_pc_i,
    input  logic               end_i,
    input  logic               abort_i,
    output ckpt_ctl_t          ctl_o,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               redirect_o,
    output logic [PC_W-1:0]    redirect_pc_o
);
    localparam logic [DEPTH_W-1:0] MAX_DEPTH = {DEPTH_W{1'b1}};
    localparam logic [DEPTH_W-1:0] ONE       = DEPTH_W'(1);

    logic [DEPTH_W-1:0] depth_q;
    logic [PC_W-1:0]    handler_q;
    logic               active, abort_eff, end_eff, begin_eff, begin_inner;

    // Decode which request wins this cycle.
    always_comb begin
        active      = (depth_q != '0);
        abort_eff   = abort_i && active;
        end_eff     = end_i && !abort_i && active;
        begin_eff   = begin_i && !abort_i && !end_i;
        begin_inner = begin_eff && active && (depth_q != MAX_DEPTH);
        ctl_o.take_snap  = begin_eff && !active;
        ctl_o.restore    = abort_eff;
        ctl_o.release_ck = end_eff && (depth_q == ONE);
    end

    // Depth counter: cleared by abort, stepped by end/begin.
    always_ff @(posedge clk) begin
        if (!rst_n)               depth_q <= '0;
        else if (abort_eff)       depth_q <= '0;
        else if (end_eff)         depth_q <= depth_q - ONE;
        else if (ctl_o.take_snap) depth_q <= ONE;
        else if (begin_inner)     depth_q <= depth_q + ONE;
    end

    // Handler PC: captured only by the outermost begin.
    always_ff @(posedge clk) begin
        if (!rst_n)               handler_q <= '0;
        else if (ctl_o.take_snap) handler_q <= begin_pc_i;
    end

    // Redirect pulse and its address, one cycle after an abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
        end else begin
            redirect_o <= abort_eff;
            if (abort_eff) redirect_pc_o <= handler_q;
        end
    end

    assign depth_o = depth_q;

    assert_abort_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_eff |=> (redirect_o && depth_q == '0 && redirect_pc_o == $past(handler_q)));
    assert_idle_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !active) |=> !redirect_o);
    assert_inner_keeps_handler_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (begin_i && active) |=> (handler_q == $past(handler_q)));
    assert_depth_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_q == MAX_DEPTH && begin_i && !end_i && !abort_i) |=> depth_q == MAX_DEPTH);
endmodule

// File: rtl/ckpt_map_table.sv
// Module: live rename map plus its snapshot copy, one entry per
// architectural register, and the occupancy mask of the live map.
// Assumes: NUM_PHYS >= NUM_ARCH so the reset identity map is legal.
module ckpt_map_table
    import rckpt_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    parameter int ARCH_W   = 3,
    parameter int PHYS_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  ckpt_ctl_t                  ctl_i,
    input  logic                       ren_we_i,
    input  logic [ARCH_W-1:0]          ren_arch_i,
    input  logic [PHYS_W-1:0]          ren_phys_i,
    output logic [NUM_ARCH*PHYS_W-1:0] map_o,
    output logic [NUM_PHYS-1:0]        occ_o
);
    logic [PHYS_W-1:0] map_q  [NUM_ARCH];
    logic [PHYS_W-1:0] snap_q [NUM_ARCH];

    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_entry
        // Snapshot copy: loaded from the pre-edge live entry on outermost begin.
        always_ff @(posedge clk) begin
            if (!rst_n)               snap_q[g] <= PHYS_W'(g);
            else if (ctl_i.take_snap) snap_q[g] <= map_q[g];
        end

        // Live entry: rollback wins over a rename write.
        always_ff @(posedge clk) begin
            if (!rst_n)             map_q[g] <= PHYS_W'(g);
            else if (ctl_i.restore) map_q[g] <= snap_q[g];
            else if (ren_we_i && ren_arch_i == ARCH_W'(g)) map_q[g] <= ren_phys_i;
        end

        assign map_o[g*PHYS_W +: PHYS_W] = map_q[g];

        assert_rollback_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_i.restore |=> (map_q[g] == $past(snap_q[g])));
    end

    // Occupancy mask: which physical registers the live map names.
    always_comb begin
        occ_o = '0;
        for (int a = 0; a < NUM_ARCH; a++) occ_o[map_q[a]] = 1'b1;
    end
endmodule

// File: rtl/ckpt_saved_bits.sv
// Module: per-physical-register protect bits. Armed from the occupancy mask
// at the outermost begin; cleared only on commit or rollback.
// Assumes: strobes come from ckpt_nest_ctrl and are mutually exclusive.
module ckpt_saved_bits
    import rckpt_pkg::*;
#(
    parameter int NUM_PHYS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  ckpt_ctl_t           ctl_i,
    input  logic [NUM_PHYS-1:0] occ_i,
    output logic [NUM_PHYS-1:0] saved_o
);
    logic [NUM_PHYS-1:0] saved_q;

    // Protect-bit register: arm on begin, drop on commit/abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    saved_q <= '0;
        else if (ctl_i.restore || ctl_i.release_ck)    saved_q <= '0;
        else if (ctl_i.take_snap)                      saved_q <= occ_i;
    end

    assign saved_o = saved_q;

    assert_saved_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_i.restore && !ctl_i.release_ck) |=> ((saved_q & $past(saved_q)) == $past(saved_q)));
    assert_saved_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.restore || ctl_i.release_ck) |=> (saved_q == '0));
endmodule

// File: rtl/rename_ckpt.sv
// Module: top of the transaction rename-map checkpoint. Connects the nesting
// controller, the map table and the protect bits.
// Assumes: rename writes come from the rename stage one per cycle.
module rename_ckpt
    import rckpt_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    parameter int PC_W     = 16,
    parameter int DEPTH_W  = 3,
    parameter int ARCH_W   = $clog2(NUM_ARCH),
    parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_begin_i,
    input  logic [PC_W-1:0]            tx_begin_pc_i,
    input  logic                       tx_end_i,
    input  logic                       tx_abort_i,
    input  logic                       ren_we_i,
    input  logic [ARCH_W-1:0]          ren_arch_i,
    input  logic [PHYS_W-1:0]          ren_phys_i,
    output logic [NUM_ARCH*PHYS_W-1:0] map_o,
    output logic [NUM_PHYS-1:0]        saved_o,
    output logic                       redirect_o,
    output logic [PC_W-1:0]            redirect_pc_o,
    output logic [DEPTH_W-1:0]         depth_o
);
    ckpt_ctl_t           ctl;
    logic [NUM_PHYS-1:0] occ;

    ckpt_nest_ctrl #(.PC_W(PC_W), .DEPTH_W(DEPTH_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .begin_i(tx_begin_i), .begin_pc_i(tx_begin_pc_i),
        .end_i(tx_end_i), .abort_i(tx_abort_i),
        .ctl_o(ctl), .depth_o(depth_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    ckpt_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS),
                     .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) u_map (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl),
        .ren_we_i(ren_we_i), .ren_arch_i(ren_arch_i), .ren_phys_i(ren_phys_i),
        .map_o(map_o), .occ_o(occ)
    );

    ckpt_saved_bits #(.NUM_PHYS(NUM_PHYS)) u_saved (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl),
        .occ_i(occ), .saved_o(saved_o)
    );

    assert_no_saved_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_o == '0) |-> (saved_o == '0));
    assert_redirect_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (depth_o == '0));
endmodule

// File: tb/sim_rename_ckpt.sv
// Bench: behavioural reference model compared with the design every cycle.
module sim_rename_ckpt;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 8, NP = 16, PCW = 16, DW = 3, AW = 3, PW = 4;
    localparam int MAXD = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic t_b = 0, t_e = 0, t_a = 0, t_we = 0;
    logic [PCW-1:0] t_pc = '0;
    logic [AW-1:0] t_ar = '0;
    logic [PW-1:0] t_ph = '0;
    logic [NA*PW-1:0] map_o;
    logic [NP-1:0] saved_o;
    logic redirect_o;
    logic [PCW-1:0] redirect_pc_o;
    logic [DW-1:0] depth_o;

    rename_ckpt #(.NUM_ARCH(NA), .NUM_PHYS(NP), .PC_W(PCW), .DEPTH_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_begin_i(t_b), .tx_begin_pc_i(t_pc),
        .tx_end_i(t_e), .tx_abort_i(t_a), .ren_we_i(t_we), .ren_arch_i(t_ar),
        .ren_phys_i(t_ph), .map_o(map_o), .saved_o(saved_o), .redirect_o(redirect_o),
        .redirect_pc_o(redirect_pc_o), .depth_o(depth_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0, cycles = 0;
    string phase = "R1";
    bit checking = 0;
    int mmap[NA], msnap[NA], mdepth, mhpc, mredpc;
    bit msaved[NP];
    bit mred;

    // Reference model: updates on each rising edge from the driven inputs.
    always @(posedge clk) begin
        bit act, ab, en, bg;
        if (!rst_n) begin
            for (int k = 0; k < NA; k++) begin mmap[k] = k; msnap[k] = k; end
            for (int k = 0; k < NP; k++) msaved[k] = 0;
            mdepth = 0; mhpc = 0; mredpc = 0; mred = 0;
        end else begin
            act = (mdepth != 0);
            ab = t_a && act;
            en = t_e && !t_a && act;
            bg = t_b && !t_a && !t_e;
            mred = ab;
            if (ab) begin
                mredpc = mhpc;
                for (int k = 0; k < NA; k++) mmap[k] = msnap[k];
                for (int k = 0; k < NP; k++) msaved[k] = 0;
                mdepth = 0;
            end else begin
                if (bg && !act) begin
                    for (int k = 0; k < NA; k++) msnap[k] = mmap[k];
                    for (int k = 0; k < NP; k++) msaved[k] = 0;
                    for (int k = 0; k < NA; k++) msaved[mmap[k]] = 1;
                    mhpc = int'(t_pc);
                    mdepth = 1;
                end else if (bg && act && mdepth < MAXD) mdepth++;
                if (en) begin
                    mdepth--;
                    if (mdepth == 0) for (int k = 0; k < NP; k++) msaved[k] = 0;
                end
                if (t_we) mmap[t_ar] = int'(t_ph);
            end
        end
    end

    task automatic chk(string what, bit ok, int act_v, int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act_v, exp_v);
        end
    endtask

    // Compare every output group with the model away from the clock edge.
    always @(negedge clk) begin
        if (checking) begin
            bit ok;
            int sv;
            ok = 1; sv = 0;
            for (int k = 0; k < NA; k++) if (int'(map_o[k*PW +: PW]) != mmap[k]) ok = 0;
            chk("map(R2)", ok, int'(map_o[PW-1:0]), mmap[0]);
            for (int k = 0; k < NP; k++) sv |= int'(msaved[k]) << k;
            chk("saved(R4)", int'(saved_o) == sv, int'(saved_o), sv);
            chk("depth(R5)", int'(depth_o) == mdepth, int'(depth_o), mdepth);
            chk("redirect(R7)", redirect_o == mred, int'(redirect_o), int'(mred));
            if (mred) chk("redirect_pc(R7)", int'(redirect_pc_o) == mredpc, int'(redirect_pc_o), mredpc);
        end
    end

    task automatic drv(bit b, int pc, bit e, bit a, bit we, int ar, int ph);
        t_b = b; t_pc = PCW'(pc); t_e = e; t_a = a; t_we = we; t_ar = AW'(ar); t_ph = PW'(ph);
        @(negedge clk);
        t_b = 0; t_e = 0; t_a = 0; t_we = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        checking = 1;
        phase = "R1"; idle(2);
        phase = "R2";
        drv(0, 0, 0, 0, 1, 0, 9); drv(0, 0, 0, 0, 1, 3, 12); drv(0, 0, 0, 0, 1, 7, 15); idle(1);
        phase = "R11"; drv(1, 16'h1200, 0, 0, 1, 3, 8);
        phase = "R3"; idle(1);
        phase = "R4"; drv(0, 0, 0, 0, 1, 0, 10); drv(0, 0, 0, 0, 1, 1, 11); idle(1);
        phase = "R5";
        for (int i = 0; i < 8; i++) drv(1, 16'h3000 + i, 0, 0, 0, 0, 0);
        phase = "R6";
        for (int i = 0; i < 8; i++) drv(0, 0, 1, 0, 0, 0, 0);
        idle(1);
        phase = "R8"; drv(0, 0, 0, 1, 0, 0, 0); idle(1);
        phase = "R7";
        drv(1, 16'hABCD, 0, 0, 0, 0, 0); drv(0, 0, 0, 0, 1, 2, 13);
        drv(1, 16'h5555, 0, 0, 0, 0, 0); drv(1, 16'h6666, 0, 0, 1, 4, 14);
        drv(0, 0, 0, 1, 0, 0, 0); idle(2);
        phase = "R9";
        drv(1, 16'h0777, 0, 0, 0, 0, 0); drv(1, 16'h0888, 0, 1, 0, 0, 0); idle(1);
        drv(1, 16'h0999, 0, 0, 0, 0, 0); drv(0, 0, 1, 1, 1, 5, 3); idle(1);
        phase = "R10";
        drv(1, 16'h0AAA, 1, 0, 0, 0, 0); idle(1);
        drv(1, 16'h0BBB, 0, 0, 0, 0, 0); drv(1, 16'h0CCC, 0, 0, 0, 0, 0);
        drv(1, 16'h0DDD, 1, 0, 0, 0, 0); drv(0, 0, 1, 0, 0, 0, 0); idle(1);
        phase = "R2";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            drv(r < 12, int'($urandom) & 16'hFFFF, (r >= 12 && r < 22) || r == 95,
                r >= 22 && r < 27, $urandom_range(0, 1) == 1,
                $urandom_range(0, NA-1), $urandom_range(0, NP-1));
        end
        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule